// File: doc/BRIEF.md
# External Memory Bus Cycle Generator

This block drives the external memory pins of an 8-bit microcontroller whose machine cycle is twelve oscillator clocks long. A CPU sequencer hands it one request per machine cycle: an instruction fetch, an external data read or an external data write. The block turns each request into the pin pattern for that machine cycle: the address latch enable, the program store, read and write strobes, the multiplexed low address/data bus and the high address byte. It also returns the bytes read from the bus.

`clk_i` is the oscillator clock. Phase numbers 0 to 11 count the clocks inside a machine cycle. A request is held on the `req_*` inputs and is taken at the clock edge that ends phase 11, while `req_ready_o` is high. It then governs phases 0 to 11 of the next machine cycle. The fetch-select input `ea_i` decides whether a fetch goes to the external program space or stays internal. A separate reset pin input is filtered so that only a pulse lasting two full machine cycles takes effect.

Top module: `ebus_cycle_gen`

## Requirements
- R1: `req_ready_o` is high during phase 11 of every machine cycle and low at all other times. A machine cycle is 12 clocks, and the request on the inputs at the edge that ends phase 11 is the one executed in the following cycle.
- R2: In fetch and idle cycles `ale_o` is high during phases 1, 2, 7 and 8 and low during all other phases.
- R3: In an external fetch `psen_no` is low during phases 4, 5, 10 and 11 and high during all other phases.
- R4: A fetch is external when `ea_i` is low, or when `ea_i` is high and the request address is above 0x1FFF. Otherwise the fetch is internal: `psen_no` stays high, the bus is not driven and no read data is returned.
- R5: In a data read `rd_no` is low during phases 4 to 9, and in a data write `wr_no` is low during phases 4 to 9. In data cycles the second ALE pulse (phases 7 and 8) is skipped and `psen_no` stays high for the whole cycle.
- R6: At most one of `psen_no`, `rd_no` and `wr_no` is low at any time, and none of them is low while `ale_o` is high.
- R7: `ad_oe_o` is high, and `ad_o` carries the low address byte, during phases 1 and 2 of every external cycle. An external fetch also drives the low byte of address+1 during phases 7 and 8. A write drives the write data during phases 3 to 10. At all other times `ad_oe_o` is low and `ad_o` is 0.
- R8: `addr_hi_o` carries the high address byte during data cycles. In an external fetch it carries the high byte of the address in phases 0 to 6 and the high byte of address+1 in phases 7 to 11. In every other cycle it is 0xFF.
- R9: `ad_i` is sampled at the edge that ends phase 5 or phase 11 of an external fetch, and at the edge that ends phase 9 of a read. The sampled byte then appears on `rdata_o`, with `rdata_valid_o` high for exactly that one following clock.
- R10: `req_kind_i` is coded 0 = fetch, 1 = data read, 2 = data write, 3 = none. Code 3, or `req_valid_i` low, gives an idle cycle: the ALE pulses continue, no strobe falls and the bus is released.
- R11: Once `rst_pin_i` has been sampled high on 24 consecutive edges, the block is held in reset for as long as the pin stays high. During that time `ale_o` is low, all strobes are high, the bus is released, `addr_hi_o` is 0xFF and `req_ready_o` is low. The phase count restarts from 0 after release. A high pulse of 23 edges or fewer has no effect.
- R12: While `rst_ni` is low, `ale_o` is low, all strobes are high, `ad_oe_o`, `rdata_valid_o` and `req_ready_o` are low, and `addr_hi_o` is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock, one phase per period |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rst_pin_i | input | 1 | Device reset pin, filtered to two machine cycles |
| ea_i | input | 1 | Fetch select: low forces external fetches |
| req_valid_i | input | 1 | A request is present |
| req_kind_i | input | 2 | 0 fetch, 1 read, 2 write, 3 none |
| req_addr_i | input | 16 | Request address |
| req_wdata_i | input | 8 | Write data |
| req_ready_o | output | 1 | Request is taken at the end of this clock |
| ad_i | input | 8 | Multiplexed bus input |
| ad_o | output | 8 | Multiplexed bus output value |
| ad_oe_o | output | 1 | Multiplexed bus drive enable |
| addr_hi_o | output | 8 | High address byte |
| ale_o | output | 1 | Address latch enable |
| psen_no | output | 1 | Program store strobe, active low |
| rd_no | output | 1 | Data read strobe, active low |
| wr_no | output | 1 | Data write strobe, active low |
| rdata_o | output | 8 | Last byte sampled from the bus |
| rdata_valid_o | output | 1 | `rdata_o` was updated at the last edge |

## Verification
The pins follow the phase count and the latched request directly, so the bench compares them in the same clock as the phase they belong to. A request becomes visible at the edge that ends phase 11, so its effect starts in phase 0 of the next cycle. Read data is due exactly one clock after the phase that samples it, and the reset filter acts one clock after its 24th high sample. The bench model advances one step per edge, so it reproduces each of these delays. All comparisons are made on the falling edge, against the state that the model has after the last rising edge.

// File: rtl/ebg_pkg.sv
package ebg_pkg;
  localparam int PH_N = 12;
  localparam int PH_W = 4;

  typedef enum logic [1:0] {
    K_FETCH = 2'd0,
    K_READ  = 2'd1,
    K_WRITE = 2'd2,
    K_NONE  = 2'd3
  } kind_e;

  typedef enum logic [2:0] {
    C_IDLE      = 3'd0,
    C_FETCH_INT = 3'd1,
    C_FETCH_EXT = 3'd2,
    C_READ      = 3'd3,
    C_WRITE     = 3'd4
  } cyc_e;
endpackage

// File: rtl/ebg_timing.sv
module ebg_timing
  import ebg_pkg::*;
#(
  parameter int RST_MCYC = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            rst_pin_i,
  output logic [PH_W-1:0] phase_o,
  output logic            last_o,
  output logic            core_rst_o
);
  localparam int HOLD  = RST_MCYC * PH_N;
  localparam int CNT_W = $clog2(HOLD + 1);

  logic [CNT_W-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     hold_q <= '0;
    else if (!rst_pin_i)             hold_q <= '0;
    else if (hold_q != CNT_W'(HOLD)) hold_q <= hold_q + 1'b1;
  end

  assign core_rst_o = (hold_q == CNT_W'(HOLD));
  assign last_o     = (phase_o == PH_W'(PH_N - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         phase_o <= '0;
    else if (core_rst_o) phase_o <= '0;
    else if (last_o)     phase_o <= '0;
    else                 phase_o <= phase_o + 1'b1;
  end

  // R1: the phase count wraps after phase 11
  a_r1_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!core_rst_o && last_o) |=> (phase_o == '0));
  // R11: a filtered reset holds the count at phase 0
  a_r11_hold_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_rst_o |=> (phase_o == '0));
endmodule

// File: rtl/ebg_cmd.sv
module ebg_cmd
  import ebg_pkg::*;
#(
  parameter int              ADDR_W  = 16,
  parameter int              DATA_W  = 8,
  parameter logic [ADDR_W-1:0] INT_TOP = 16'h1FFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              core_rst_i,
  input  logic              last_i,
  input  logic              req_valid_i,
  input  logic [1:0]        req_kind_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              ea_i,
  output cyc_e              cyc_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o
);
  cyc_e  cyc_d;
  kind_e kind;

  always_comb begin
    kind  = kind_e'(req_kind_i);
    cyc_d = C_IDLE;
    if (req_valid_i) begin
      unique case (kind)
        K_FETCH: cyc_d = (!ea_i || req_addr_i > INT_TOP) ? C_FETCH_EXT : C_FETCH_INT;
        K_READ:  cyc_d = C_READ;
        K_WRITE: cyc_d = C_WRITE;
        default: cyc_d = C_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_o   <= C_IDLE;
      addr_o  <= '0;
      wdata_o <= '0;
    end else if (core_rst_i) begin
      cyc_o   <= C_IDLE;
    end else if (last_i) begin
      cyc_o   <= cyc_d;
      addr_o  <= req_addr_i;
      wdata_o <= req_wdata_i;
    end
  end

  // R1: the cycle type only changes at a machine cycle boundary or in reset
  a_r1_cyc_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!last_i && !core_rst_i) |=> $stable(cyc_o));
endmodule

// File: rtl/ebg_strobe.sv
module ebg_strobe
  import ebg_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     core_rst_i,
  input  logic [PH_W-1:0]          phase_i,
  input  cyc_e                     cyc_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [DATA_W-1:0]        wdata_i,
  input  logic [DATA_W-1:0]        ad_i,
  output logic [DATA_W-1:0]        ad_o,
  output logic                     ad_oe_o,
  output logic [ADDR_W-DATA_W-1:0] addr_hi_o,
  output logic                     ale_o,
  output logic                     psen_no,
  output logic                     rd_no,
  output logic                     wr_no,
  output logic [DATA_W-1:0]        rdata_o,
  output logic                     rdata_valid_o
);
  localparam int HI_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] addr_nxt;
  logic live, is_data, is_ext, ext_fetch;
  logic win_ale_a, win_ale_b, win_psen, win_dstb, win_wdat, cap;

  assign addr_nxt = addr_i + 1'b1;
  assign live      = !core_rst_i;
  assign ext_fetch = (cyc_i == C_FETCH_EXT);
  assign is_data   = (cyc_i == C_READ) || (cyc_i == C_WRITE);
  assign is_ext    = ext_fetch || is_data;

  // phase windows inside the machine cycle
  always_comb begin
    win_ale_a = (phase_i == 4'd1) || (phase_i == 4'd2);
    win_ale_b = (phase_i == 4'd7) || (phase_i == 4'd8);
    win_psen  = (phase_i == 4'd4) || (phase_i == 4'd5) ||
                (phase_i == 4'd10) || (phase_i == 4'd11);
    win_dstb  = (phase_i >= 4'd4) && (phase_i <= 4'd9);
    win_wdat  = (phase_i >= 4'd3) && (phase_i <= 4'd10);
  end

  assign ale_o   = live && (win_ale_a || (win_ale_b && !is_data));
  assign psen_no = !(live && ext_fetch && win_psen);
  assign rd_no   = !(live && cyc_i == C_READ && win_dstb);
  assign wr_no   = !(live && cyc_i == C_WRITE && win_dstb);

  always_comb begin
    ad_oe_o = 1'b0;
    ad_o    = '0;
    if (live) begin
      if (is_ext && win_ale_a) begin
        ad_oe_o = 1'b1;
        ad_o    = addr_i[DATA_W-1:0];
      end else if (ext_fetch && win_ale_b) begin
        ad_oe_o = 1'b1;
        ad_o    = addr_nxt[DATA_W-1:0];
      end else if (cyc_i == C_WRITE && win_wdat) begin
        ad_oe_o = 1'b1;
        ad_o    = wdata_i;
      end
    end
  end

  always_comb begin
    if (!live || !is_ext)                addr_hi_o = '1;
    else if (ext_fetch && phase_i >= 4'd7) addr_hi_o = addr_nxt[ADDR_W-1:DATA_W];
    else                                 addr_hi_o = addr_i[ADDR_W-1:DATA_W];
  end

  // sample on the last low phase of each read strobe
  assign cap = live && ((ext_fetch && (phase_i == 4'd5 || phase_i == 4'd11)) ||
                        (cyc_i == C_READ && phase_i == 4'd9));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o       <= '0;
      rdata_valid_o <= 1'b0;
    end else begin
      rdata_valid_o <= cap;
      if (cap) rdata_o <= ad_i;
    end
  end

  // R6: one strobe at a time
  a_r6_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({~psen_no, ~rd_no, ~wr_no}) <= 1);
  // R6: no strobe while the address latch is open
  a_r6_ale_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> (psen_no && rd_no && wr_no));
  // R2: ALE only rises at the start of state 1 or state 4
  a_r2_ale_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ale_o) |-> (phase_i == 4'd1 || phase_i == 4'd7));
  // R4: program store strobe only for external fetches
  a_r4_psen_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !psen_no |-> (cyc_i == C_FETCH_EXT));
  // R5: the second latch pulse is skipped in data cycles
  a_r5_skip_ale: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_data && win_ale_b) |-> !ale_o);
  // R9: read data valid lasts one clock
  a_r9_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_valid_o |=> !rdata_valid_o);
  // R7: bus released whenever a read strobe is low
  a_r7_bus_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!psen_no || !rd_no) |-> !ad_oe_o);

  if (HI_W < 1) begin : g_bad_width
    initial $error("ebg_strobe: ADDR_W must exceed DATA_W");
  end
endmodule

// File: rtl/ebus_cycle_gen.sv
module ebus_cycle_gen
  import ebg_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter int                DATA_W   = 8,
  parameter logic [ADDR_W-1:0] INT_TOP  = 16'h1FFF,
  parameter int                RST_MCYC = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     rst_pin_i,
  input  logic                     ea_i,
  input  logic                     req_valid_i,
  input  logic [1:0]               req_kind_i,
  input  logic [ADDR_W-1:0]        req_addr_i,
  input  logic [DATA_W-1:0]        req_wdata_i,
  output logic                     req_ready_o,
  input  logic [DATA_W-1:0]        ad_i,
  output logic [DATA_W-1:0]        ad_o,
  output logic                     ad_oe_o,
  output logic [ADDR_W-DATA_W-1:0] addr_hi_o,
  output logic                     ale_o,
  output logic                     psen_no,
  output logic                     rd_no,
  output logic                     wr_no,
  output logic [DATA_W-1:0]        rdata_o,
  output logic                     rdata_valid_o
);
  logic [PH_W-1:0]   phase;
  logic              last, core_rst;
  cyc_e              cyc;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  ebg_timing #(.RST_MCYC(RST_MCYC)) u_timing (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rst_pin_i  (rst_pin_i),
    .phase_o    (phase),
    .last_o     (last),
    .core_rst_o (core_rst)
  );

  ebg_cmd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .INT_TOP(INT_TOP)) u_cmd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .core_rst_i  (core_rst),
    .last_i      (last),
    .req_valid_i (req_valid_i),
    .req_kind_i  (req_kind_i),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .ea_i        (ea_i),
    .cyc_o       (cyc),
    .addr_o      (addr_q),
    .wdata_o     (wdata_q)
  );

  ebg_strobe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_strobe (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .core_rst_i    (core_rst),
    .phase_i       (phase),
    .cyc_i         (cyc),
    .addr_i        (addr_q),
    .wdata_i       (wdata_q),
    .ad_i          (ad_i),
    .ad_o          (ad_o),
    .ad_oe_o       (ad_oe_o),
    .addr_hi_o     (addr_hi_o),
    .ale_o         (ale_o),
    .psen_no       (psen_no),
    .rd_no         (rd_no),
    .wr_no         (wr_no),
    .rdata_o       (rdata_o),
    .rdata_valid_o (rdata_valid_o)
  );

  assign req_ready_o = last && !core_rst;

  // R1: ready is a single-clock pulse per machine cycle
  a_r1_ready_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |=> !req_ready_o);
  // R11: no bus activity while the reset pin filter holds the block
  a_r11_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_rst |-> (!ale_o && psen_no && rd_no && wr_no && !ad_oe_o && !req_ready_o));
endmodule

// File: tb/sim_ebus_cycle_gen.sv
module sim_ebus_cycle_gen;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rst_pin = 1'b0, ea = 1'b0, req_valid = 1'b0;
  logic [1:0] req_kind = 2'd3;
  logic [15:0] req_addr = '0;
  logic [7:0] req_wdata = '0, ad_in = '0;
  logic       req_ready, ad_oe, ale, psen_n, rd_n, wr_n, rdata_valid;
  logic [7:0] ad_out, addr_hi, rdata;

  int total = 0, bad = 0, step_no = 0;
  bit done = 0;

  // behavioural model: kind 0 idle, 1 internal fetch, 2 external fetch, 3 read, 4 write
  int m_ph = 0, m_kind = 0, m_cnt = 0;
  logic [15:0] m_addr = '0;
  logic [7:0]  m_wd = '0, m_rdata = '0;
  bit          m_valid = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ebus_cycle_gen u0 (
    .clk_i(clk), .rst_ni(rst_ni), .rst_pin_i(rst_pin), .ea_i(ea),
    .req_valid_i(req_valid), .req_kind_i(req_kind), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .req_ready_o(req_ready), .ad_i(ad_in),
    .ad_o(ad_out), .ad_oe_o(ad_oe), .addr_hi_o(addr_hi), .ale_o(ale),
    .psen_no(psen_n), .rd_no(rd_n), .wr_no(wr_n), .rdata_o(rdata),
    .rdata_valid_o(rdata_valid)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s step=%0d phase=%0d actual=%h expected=%h", tag, what, step_no, m_ph, act, exp);
    end
  endtask

  task automatic check_all(input string force_tag);
    bit rst, e_ale, e_psen, e_rd, e_wr, e_oe, e_rdy;
    logic [7:0] e_ad, e_hi;
    logic [15:0] nxt;
    string t;
    rst = (m_cnt >= 24);
    nxt = m_addr + 16'd1;
    e_ale  = !rst && (m_ph == 1 || m_ph == 2 || ((m_ph == 7 || m_ph == 8) && m_kind < 3));
    e_psen = !(!rst && m_kind == 2 && (m_ph == 4 || m_ph == 5 || m_ph == 10 || m_ph == 11));
    e_rd   = !(!rst && m_kind == 3 && m_ph >= 4 && m_ph <= 9);
    e_wr   = !(!rst && m_kind == 4 && m_ph >= 4 && m_ph <= 9);
    e_oe   = !rst && ((m_kind >= 2 && (m_ph == 1 || m_ph == 2)) ||
                      (m_kind == 2 && (m_ph == 7 || m_ph == 8)) ||
                      (m_kind == 4 && m_ph >= 3 && m_ph <= 10));
    if (!e_oe) e_ad = 8'h00;
    else if (m_ph == 1 || m_ph == 2) e_ad = m_addr[7:0];
    else if (m_kind == 2) e_ad = nxt[7:0];
    else e_ad = m_wd;
    if (rst || m_kind < 2) e_hi = 8'hFF;
    else if (m_kind == 2 && m_ph >= 7) e_hi = nxt[15:8];
    else e_hi = m_addr[15:8];
    e_rdy = !rst && m_ph == 11;

    t = force_tag != "" ? force_tag : rst ? "R11" : m_kind == 0 ? "R10" : m_kind >= 3 ? "R5" : "R2";
    chk(t, ale, e_ale, "ale");
    t = force_tag != "" ? force_tag : rst ? "R11" : m_kind == 1 ? "R4" : m_kind == 0 ? "R10" : "R3";
    chk(t, psen_n, e_psen, "psen_n");
    t = force_tag != "" ? force_tag : rst ? "R11" : m_kind == 0 ? "R10" : "R5";
    chk(t, rd_n, e_rd, "rd_n");
    chk(t, wr_n, e_wr, "wr_n");
    t = force_tag != "" ? force_tag : rst ? "R11" : m_kind == 1 ? "R4" : "R7";
    chk(t, ad_oe, e_oe, "ad_oe");
    chk(t, ad_out, e_ad, "ad_o");
    t = force_tag != "" ? force_tag : rst ? "R11" : "R8";
    chk(t, addr_hi, e_hi, "addr_hi");
    t = force_tag != "" ? force_tag : "R9";
    chk(t, rdata_valid, m_valid, "rdata_valid");
    if (m_valid) chk("R9", rdata, m_rdata, "rdata");
    t = force_tag != "" ? force_tag : rst ? "R11" : "R1";
    chk(t, req_ready, e_rdy, "req_ready");
    // R6: strobe exclusivity seen at the pins
    chk("R6", ((!psen_n + !rd_n + !wr_n) <= 1) && !(ale && (!psen_n || !rd_n || !wr_n)), 1, "strobe overlap");
  endtask

  task automatic advance();
    bit rst, cap;
    rst = (m_cnt >= 24);
    cap = !rst && ((m_kind == 2 && (m_ph == 5 || m_ph == 11)) || (m_kind == 3 && m_ph == 9));
    m_valid = cap;
    if (cap) m_rdata = ad_in;
    if (rst) begin
      m_ph = 0;
      m_kind = 0;
    end else begin
      if (m_ph == 11) begin
        if (!req_valid || req_kind == 2'd3) m_kind = 0;
        else if (req_kind == 2'd0) m_kind = (!ea || req_addr > 16'h1FFF) ? 2 : 1;
        else if (req_kind == 2'd1) m_kind = 3;
        else m_kind = 4;
        m_addr = req_addr;
        m_wd = req_wdata;
      end
      m_ph = (m_ph + 1) % 12;
    end
    m_cnt = rst_pin ? ((m_cnt < 24) ? m_cnt + 1 : 24) : 0;
  endtask

  task automatic step(input bit v, input logic [1:0] k, input logic [15:0] a,
                      input logic [7:0] w, input bit e, input bit rp);
    @(negedge clk);
    check_all("");
    step_no++;
    req_valid = v; req_kind = k; req_addr = a; req_wdata = w; ea = e; rst_pin = rp;
    ad_in = 8'(step_no * 37 + 5);
    advance();
  endtask

  task automatic run_cycle(input bit v, input logic [1:0] k, input logic [15:0] a,
                           input logic [7:0] w, input bit e);
    for (int i = 0; i < 12; i++) step(v, k, a, w, e, 1'b0);
  endtask

  task automatic pin_high(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 2'd3, 16'h0, 8'h0, 1'b1, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_all("R12");
    rst_ni = 1'b1;
    advance();
    run_cycle(0, 2'd0, 16'h0000, 8'h00, 1);   // R10 idle
    run_cycle(1, 2'd0, 16'h0100, 8'h00, 0);   // R3 external fetch, ea low
    run_cycle(1, 2'd0, 16'h1FFF, 8'h00, 1);   // R4 internal at the limit
    run_cycle(1, 2'd0, 16'h2000, 8'h00, 1);   // R4 external above the limit
    run_cycle(1, 2'd0, 16'h12FF, 8'h00, 0);   // R8 high byte carries
    run_cycle(1, 2'd1, 16'h8034, 8'h00, 1);   // R5 read
    run_cycle(1, 2'd2, 16'hA55A, 8'h3C, 1);   // R5 write
    run_cycle(1, 2'd3, 16'h4321, 8'h77, 0);   // R10 kind none
    run_cycle(1, 2'd1, 16'hFFFF, 8'h00, 0);   // R9 read
    run_cycle(1, 2'd2, 16'h0000, 8'hC3, 0);   // R7 write data
    run_cycle(1, 2'd0, 16'hFFFF, 8'h00, 1);   // R8 address wraps
    pin_high(23);                             // R11 too short
    run_cycle(1, 2'd0, 16'h0456, 8'h00, 0);
    pin_high(30);                             // R11 filtered reset
    run_cycle(1, 2'd2, 16'h3344, 8'h5A, 1);
    run_cycle(1, 2'd0, 16'h0042, 8'h00, 0);
    run_cycle(0, 2'd0, 16'h0000, 8'h00, 1);
    @(negedge clk);
    check_all("");
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule